// File: doc/BRIEF.md
# Strap-Sensing LED Driver

This block owns a group of shared pins that act as hardware configuration straps while reset is held and as LED drivers once reset is released. During reset every pin is left undriven and its level is captured on each clock; the last value captured before release is kept as that pin's strap. After release the pins are driven, and each captured strap decides whether that LED is lit by a low or a high level, so a board designer picks both the configuration value and the LED wiring with one resistor.

Each LED shows one status bit selected from a status vector. A lit indication can be stretched so that short activity pulses stay visible, gated by a shared 8-bit blink pattern stepped at a programmable rate, and paired with its neighbour in a two-colour mode that never lets both LEDs of the pair light together. With a base tick of 1 ms, the pattern `8'hF0` and the divide field at 63 give a 512 ms blink period.

Top module: `strap_led_drv`

## Requirements
- R1: While `rst_n` is low, `pad_oe` and `pad_out` are all zero.
- R2: Each pin's strap is the `pad_in` level sampled on the last clock edge with `rst_n` low; later changes on `pad_in` have no effect on the outputs.
- R3: `pad_oe` is all ones from the first clock edge with `rst_n` high.
- R4: A lit LED whose strap is 1 drives `pad_out` low and drives it high when unlit; with strap 0 the levels are swapped.
- R5: LED i follows `status[src_sel[i*SEL_W +: SEL_W]]`, registered once, when its stretch, blink and pairing are off.
- R6: A base tick occurs every `BASE_CYC` clocks after reset; the blink index (0 after reset) advances by one every `blink_div`+1 base ticks, and an LED with `blink_en` set is lit only while `blink_pat[index]` is 1.
- R7: With `hold_en` set, a high source loads a hold count of `HOLD_TICKS`, each base tick with the source low lowers it by one, and the LED stays lit while the count is non-zero.
- R8: With `pair_en[k]` set, LED 2k is lit only when its own indication is on and LED 2k+1's indication is off, so the pair never lights together; LED 2k+1 is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps sampled while low |
| pad_in | input | N_LED | Pin levels read back from the pads |
| pad_out | output | N_LED | Pin drive values |
| pad_oe | output | N_LED | Pin output enables |
| status | input | N_SRC | Status bits available as LED sources |
| src_sel | input | N_LED*SEL_W | Source index for each LED |
| hold_en | input | N_LED | Pulse stretch enable per LED |
| blink_en | input | N_LED | Blink gating enable per LED |
| blink_pat | input | 8 | Shared blink pattern |
| blink_div | input | 6 | Base ticks per pattern step, minus one |
| pair_en | input | N_LED/2 | Two-colour mode per LED pair |

## Verification
The assertions take the control inputs to be stable around each clock edge and `N_LED` to be even so that every pair is complete; the bench changes all inputs only on falling edges and uses four LEDs. The source-following check assumes that an LED with stretch, blink and pairing off shows exactly its selected bit one edge later, so the stimulus toggles those enables only between phases while comparing every cycle against a behavioural model. Strap levels are changed both during and after reset to show that only the final reset sample counts.

// File: rtl/strap_led_drv.sv
`timescale 1ns/1ps
module strap_led_drv #(
  parameter int N_LED      = 4,
  parameter int N_SRC      = 4,
  parameter int BASE_CYC   = 125000,
  parameter int HOLD_TICKS = 32,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_LED-1:0]       pad_in,
  output logic [N_LED-1:0]       pad_out,
  output logic [N_LED-1:0]       pad_oe,
  input  logic [N_SRC-1:0]       status,
  input  logic [N_LED*SEL_W-1:0] src_sel,
  input  logic [N_LED-1:0]       hold_en,
  input  logic [N_LED-1:0]       blink_en,
  input  logic [7:0]             blink_pat,
  input  logic [5:0]             blink_div,
  input  logic [N_LED/2-1:0]     pair_en
);
  localparam int PW = (BASE_CYC > 1) ? $clog2(BASE_CYC) : 1;
  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic             run_q;
  logic [N_LED-1:0] strap_q, lit_q;
  logic [PW-1:0]    pre_q;
  logic [5:0]       div_q;
  logic [2:0]       idx_q;
  logic [N_LED-1:0] src, ind, lit_d;
  logic             base_tick, step;

  assign base_tick = (pre_q == PW'(BASE_CYC - 1));
  assign step      = base_tick && (div_q >= blink_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      strap_q <= pad_in;
      pre_q   <= '0;
      div_q   <= '0;
      idx_q   <= '0;
      lit_q   <= '0;
    end else begin
      run_q <= 1'b1;
      lit_q <= lit_d;
      pre_q <= base_tick ? '0 : pre_q + 1'b1;
      if (base_tick) begin
        div_q <= step ? '0 : div_q + 1'b1;
        if (step) idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign pad_oe  = {N_LED{run_q}};
  assign pad_out = (lit_q ^ strap_q) & {N_LED{run_q}};

  for (genvar i = 0; i < N_LED; i++) begin : g_led
    logic [HW-1:0] hold_q;
    logic          pair_gate;

    assign src[i] = status[src_sel[i*SEL_W +: SEL_W]];
    assign ind[i] = (src[i] | (hold_en[i] & (hold_q != '0)))
                    & (~blink_en[i] | blink_pat[idx_q]);

    always_ff @(posedge clk) begin
      if (!rst_n)                         hold_q <= '0;
      else if (src[i])                    hold_q <= HW'(HOLD_TICKS);
      else if (base_tick && hold_q != '0) hold_q <= hold_q - 1'b1;
    end

    if (i % 2 == 0) begin : g_even
      assign pair_gate = pair_en[i/2];
      assign lit_d[i]  = ind[i] & ~(pair_gate & ind[i+1]);
    end else begin : g_odd
      assign pair_gate = 1'b0;
      assign lit_d[i]  = ind[i];
    end

    // R5
    src_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_en[i] && !blink_en[i] && !pair_gate) |=> lit_q[i] == $past(src[i]));

    // R4
    polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> pad_out[i] == (lit_q[i] ? !strap_q[i] : strap_q[i]));

    if (i % 2 == 0) begin : g_pchk
      // R8
      pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_en[i/2] |=> !(lit_q[i] && lit_q[i+1]));
    end
  end

  // R1
  oe_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && pad_out == '0));

  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(strap_q));

  // R3
  oe_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> &pad_oe);
endmodule

// File: tb/sim_strap_led_drv.sv
`timescale 1ns/1ps
module sim_strap_led_drv;
  localparam int N = 4, S = 4, SW = 2, BASE = 3, HOLD = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] pad_in = '0, pad_out, pad_oe;
  logic [S-1:0] status = '0;
  logic [N*SW-1:0] src_sel = '0;
  logic [N-1:0] hold_en = '0, blink_en = '0;
  logic [7:0] blink_pat = '0;
  logic [5:0] blink_div = '0;
  logic [N/2-1:0] pair_en = '0;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  strap_led_drv #(.N_LED(N), .N_SRC(S), .BASE_CYC(BASE), .HOLD_TICKS(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .status(status), .src_sel(src_sel), .hold_en(hold_en), .blink_en(blink_en),
    .blink_pat(blink_pat), .blink_div(blink_div), .pair_en(pair_en));

  // behavioural reference
  int m_run = 0, m_pre = 0, m_div = 0, m_idx = 0;
  int m_strap[N], m_hold[N], m_lit[N];
  initial for (int i = 0; i < N; i++) begin m_strap[i] = 0; m_hold[i] = 0; m_lit[i] = 0; end

  always @(posedge clk) begin
    int ind[N];
    int src;
    bit tick;
    tick = (m_pre == BASE - 1);
    if (!rst_n) begin
      m_run = 0; m_pre = 0; m_div = 0; m_idx = 0;
      for (int i = 0; i < N; i++) begin m_strap[i] = pad_in[i]; m_hold[i] = 0; m_lit[i] = 0; end
    end else begin
      for (int i = 0; i < N; i++) begin
        src = status[src_sel[i*SW +: SW]];
        ind[i] = (src != 0 || (hold_en[i] && m_hold[i] > 0)) && (!blink_en[i] || blink_pat[m_idx]);
        if (src != 0) m_hold[i] = HOLD;
        else if (tick && m_hold[i] > 0) m_hold[i]--;
      end
      for (int i = 0; i < N; i++)
        m_lit[i] = (i % 2 == 0 && pair_en[i/2]) ? (ind[i] && !ind[i+1]) : ind[i];
      if (tick) begin
        if (m_div >= blink_div) begin m_div = 0; m_idx = (m_idx + 1) % 8; end
        else m_div++;
      end
      m_pre = tick ? 0 : m_pre + 1;
      m_run = 1;
    end
  end

  task automatic compare();
    logic [N-1:0] e_oe, e_out;
    for (int i = 0; i < N; i++) begin
      e_oe[i]  = (m_run != 0);
      e_out[i] = (m_run != 0) ? ((m_lit[i] != 0) ^ (m_strap[i] != 0)) : 1'b0;
    end
    checks++;
    if (pad_oe !== e_oe || pad_out !== e_out) begin
      errors++;
      $display("FAIL %s oe=%b out=%b expected oe=%b out=%b", tag, pad_oe, pad_out, e_oe, e_out);
    end
  endtask

  task automatic cycles(input int n, input bit rnd_status, input int sparse);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
      if (rnd_status) status = ($urandom % sparse == 0) ? S'($urandom) : '0;
    end
  endtask

  initial begin
    // R1 and R2: reset with straps changing, last sample wins
    tag = "R1"; pad_in = 4'b1111;
    cycles(3, 0, 1);
    pad_in = 4'b0110;
    cycles(3, 0, 1);
    // R3 R4 R5: plain source following, strap pins then disturbed
    rst_n = 1'b1; tag = "R3";
    src_sel = {2'd0, 2'd1, 2'd2, 2'd3};
    cycles(2, 0, 1);
    tag = "R2"; pad_in = 4'b1001;
    status = 4'b0000; cycles(2, 0, 1);
    tag = "R4"; status = 4'b1111; cycles(2, 0, 1);
    tag = "R5";
    for (int v = 0; v < 16; v++) begin status = 4'(v); cycles(1, 0, 1); end
    cycles(20, 1, 1);
    // R7: stretch of sparse pulses
    tag = "R7"; hold_en = 4'b1011; status = '0;
    cycles(80, 1, 9);
    status = 4'b1111; cycles(1, 0, 1); status = '0; cycles(25, 0, 1);
    // R6: blink patterns at two rates
    tag = "R6"; hold_en = '0; blink_en = 4'b1101; status = 4'b1111;
    blink_pat = 8'b1011_0010; blink_div = 6'd2;
    cycles(160, 0, 1);
    blink_div = 6'd0; blink_pat = 8'b0110_1001;
    cycles(60, 0, 1);
    // R8: two-colour pairing
    tag = "R8"; blink_en = '0; pair_en = 2'b11; src_sel = {2'd1, 2'd0, 2'd3, 2'd2};
    cycles(80, 1, 1);
    pair_en = 2'b01; cycles(40, 1, 1);
    // R2: second reset with other straps, then everything at once
    tag = "R2"; rst_n = 1'b0; pad_in = 4'b1001; cycles(4, 0, 1);
    rst_n = 1'b1; pad_in = 4'b0000;
    hold_en = 4'b0110; blink_en = 4'b1010; pair_en = 2'b10;
    blink_pat = 8'b1110_0101; blink_div = 6'd1;
    for (int r = 0; r < 6; r++) begin
      src_sel = N*SW'($urandom);
      cycles(60, 1, 3);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule